// File: doc/BRIEF.md
# Table-Seeded Floating-Point Divider and Reciprocal Unit

This block divides one floating-point operand by another, or returns the reciprocal of the second operand alone. Both operands use a packed format: a sign bit, then a biased exponent of `EXP_W` bits, then a stored fraction of `FRAC_W` bits with a hidden leading one. The significand of the divisor is first cut to its top k fraction bits, where k = floor((m+2)/4)+1 and m = `FRAC_W`+1. Those k bits index a seed table of rounded reciprocals R, which is computed by a constant function when the design is elaborated. The block then forms the small residual A = Y·R − 1. It splits A into k-bit chunks, evaluates a short power series for 1/(1+A) from those chunks, and multiplies R, the series value and the dividend significand together.

Sign and exponent are worked out on their own short paths next to the significand path. The result comes out one clock after a valid input. It is not normalised and not rounded: the significand is wide, with a single integer bit, and the exponent is a signed field two bits wider than the operand's exponent. A divisor equal to zero raises the exception output. In every other case the exception input is passed through. A later stage is expected to normalise, round and handle special values.

Top module: `fp_recip_div`

## Requirements
- R1: `out_valid` is high exactly in the cycle after a cycle in which `in_valid` is high. The result fields in that cycle belong to that input.
- R2: In divide mode (`in_recip` = 0), `out_sign` is the XOR of the two operand sign bits. The sign bit is the most significant bit of each operand.
- R3: In divide mode, the signed value of `out_exp` equals Ex − Ey + bias, where bias = 2^(EXP_W−1) − 1 and Ex, Ey are the raw exponent fields.
- R4: In reciprocal mode (`in_recip` = 1), `out_sign` equals the sign of y and `out_exp` equals 2·bias − Ey. Operand x has no effect on any output.
- R5: In divide mode with a nonzero divisor, `out_mant`/2^(FRAC_W+9) differs from (1.fx)/(1.fy) by at most 2^−FRAC_W, which is one unit in the last place of an m-bit significand.
- R6: In reciprocal mode with a nonzero divisor, `out_mant`/2^(FRAC_W+9) differs from 1/(1.fy) by at most 2^−FRAC_W.
- R7: When both the exponent field and the fraction field of y are zero, `out_exc` is 1, whatever the value of `in_exc`. A zero exponent with a nonzero fraction does not count as zero.
- R8: For any other divisor, `out_exc` equals the `in_exc` sampled with the operands.
- R9: When the fraction of y is zero, `out_mant` is exact. It equals (1.fx)·2^(FRAC_W+9) in divide mode and 2^(FRAC_W+9) in reciprocal mode.
- R10: While `rst_n` is low, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operands and mode are valid this cycle |
| in_recip | input | 1 | 1 = reciprocal of y, 0 = x divided by y |
| in_exc | input | 1 | Exception flag arriving with the operands |
| x_op | input | EXP_W+FRAC_W+1 | Dividend {sign, exponent, fraction} |
| y_op | input | EXP_W+FRAC_W+1 | Divisor {sign, exponent, fraction} |
| out_valid | output | 1 | Result valid |
| out_sign | output | 1 | Result sign |
| out_exp | output | EXP_W+2 | Signed, biased, unnormalised result exponent |
| out_mant | output | FRAC_W+10 | Unrounded significand, 1 integer bit and FRAC_W+9 fraction bits |
| out_exc | output | 1 | Exception flag |

## Verification
The bench builds the block with `EXP_W` = 8 and `FRAC_W` = 23. That gives k = 7 and a seed table of 128 entries. At this size the bench can sweep every table index in both modes, and the full 24-bit significand accuracy can be compared against a real-valued quotient. Exponent fields are driven at both extremes, so the widened signed exponent is checked for headroom in the positive and the negative direction. Zero divisors, denormal-looking divisors and a unit divisor (the exact-result case) are also driven.

// File: rtl/fp_recip_div.sv
module fp_recip_div #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic                     in_recip,
  input  logic                     in_exc,
  input  logic [EXP_W+FRAC_W:0]    x_op,
  input  logic [EXP_W+FRAC_W:0]    y_op,
  output logic                     out_valid,
  output logic                     out_sign,
  output logic signed [EXP_W+1:0]  out_exp,
  output logic [FRAC_W+9:0]        out_mant,
  output logic                     out_exc
);
  localparam int M    = FRAC_W + 1;
  localparam int K    = (M + 2) / 4 + 1;
  localparam int RW   = K + 3;
  localparam int PW   = M + RW + 1;
  localparam int SH   = M + K + 1 - 4 * K;
  localparam int BW   = 6 * K + 4;
  localparam int QF   = M + 8;
  localparam int QW   = QF + 1;
  localparam int SHQ  = 7 * K + M + 1 - QF;
  localparam int EW   = EXP_W + 2;
  localparam int BIAS = (1 << (EXP_W - 1)) - 1;
  localparam logic signed [BW-1:0] ONE_B = BW'(1) <<< (6 * K);

  function automatic logic [RW-1:0] seed_of(int i);
    longint num, den, quo;
    num = longint'(1) << (2 * K + 3);
    den = (longint'(1) << K) + longint'(i);
    quo = num / den;
    return RW'((quo + 1) >> 1);
  endfunction

  logic              sx, sy;
  logic [EXP_W-1:0]  ex, ey;
  logic [FRAC_W-1:0] fx, fy;
  assign {sx, ex, fx} = x_op;
  assign {sy, ey, fy} = y_op;

  logic [M-1:0] xi, yi, xsel;
  assign xi   = {1'b1, fx};
  assign yi   = {1'b1, fy};
  assign xsel = in_recip ? {1'b1, {FRAC_W{1'b0}}} : xi;

  logic [RW-1:0] rtab [1<<K];
  for (genvar g = 0; g < (1 << K); g++) begin : g_seed
    assign rtab[g] = seed_of(g);
  end

  logic [K-1:0]  idx;
  logic [RW-1:0] r;
  assign idx = fy[FRAC_W-1 -: K];
  assign r   = rtab[idx];

  logic signed [PW-1:0] pfull, a;
  assign pfull = $signed(PW'(yi) * PW'(r) - (PW'(1) << (M + K + 1)));

  if (SH >= 0) begin : g_shr
    assign a = pfull >>> SH;
  end else begin : g_shl
    assign a = pfull <<< (-SH);
  end

  logic signed [BW-1:0] a_e, a2, a3, b;
  assign a_e = BW'(a);
  assign a2  = a_e >>> (2 * K);
  assign a3  = $signed({{(BW-K){1'b0}}, a_e[2*K-1:K]});
  assign b   = ONE_B - (a_e <<< (2 * K)) + ((a2 * a2) <<< (2 * K))
             + ((a2 * a3) <<< (K + 1)) - (a2 * a2 * a2);

  logic [RW+BW-1:0] rb;
  logic [QW-1:0]    q_mant;
  assign rb     = (RW+BW)'(r) * (RW+BW)'($unsigned(b));
  assign q_mant = QW'(((RW+BW+M)'(rb) * (RW+BW+M)'(xsel)) >> SHQ);

  logic signed [EW-1:0] ex_s, ey_s, q_exp;
  assign ex_s  = $signed({2'b00, ex});
  assign ey_s  = $signed({2'b00, ey});
  assign q_exp = in_recip ? (EW'(2 * BIAS) - ey_s) : (ex_s - ey_s + EW'(BIAS));

  logic y_zero;
  assign y_zero = (ey == '0) && (fy == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_sign  <= 1'b0;
      out_exp   <= '0;
      out_mant  <= '0;
      out_exc   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_sign <= in_recip ? sy : (sx ^ sy);
        out_exp  <= q_exp;
        out_mant <= q_mant;
        out_exc  <= y_zero | in_exc;
      end
    end
  end
endmodule

// File: rtl/fp_recip_div_chk.sv
module fp_recip_div_chk #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    in_valid,
  input logic                    in_recip,
  input logic                    in_exc,
  input logic [EXP_W+FRAC_W:0]   x_op,
  input logic [EXP_W+FRAC_W:0]   y_op,
  input logic                    out_valid,
  input logic                    out_sign,
  input logic signed [EXP_W+1:0] out_exp,
  input logic [FRAC_W+9:0]       out_mant,
  input logic                    out_exc
);
  localparam int MSB  = EXP_W + FRAC_W;
  localparam int BIAS = (1 << (EXP_W - 1)) - 1;

  logic div_by_zero, unit_div;
  logic signed [EXP_W+1:0] rexp_ref;
  logic [FRAC_W+9:0] exact_ref;
  assign div_by_zero = (y_op[MSB-1:0] == '0);
  assign unit_div    = (y_op[FRAC_W-1:0] == '0);
  assign rexp_ref    = (EXP_W+2)'(2 * BIAS) - $signed({2'b00, y_op[MSB-1:FRAC_W]});
  assign exact_ref   = in_recip ? ((FRAC_W+10)'(1) << (FRAC_W + 9))
                                : ((FRAC_W+10)'({1'b1, x_op[FRAC_W-1:0]}) << 9);

  // R1
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  // R1
  idle_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  // R2
  div_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_recip) |=> (out_sign == $past(x_op[MSB] ^ y_op[MSB])));
  // R4
  recip_exp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_recip) |=> (out_exp == $past(rexp_ref)));
  // R7
  zero_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && div_by_zero) |=> out_exc);
  // R8
  exc_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !div_by_zero) |=> (out_exc == $past(in_exc)));
  // R9
  unit_exact_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && unit_div && !div_by_zero) |=> (out_mant == $past(exact_ref)));
endmodule

bind fp_recip_div fp_recip_div_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_recip(in_recip),
  .in_exc(in_exc), .x_op(x_op), .y_op(y_op), .out_valid(out_valid),
  .out_sign(out_sign), .out_exp(out_exp), .out_mant(out_mant), .out_exc(out_exc)
);

// File: tb/fp_recip_div_bench.sv
`timescale 1ns/1ps
module fp_recip_div_bench;
  localparam int EXP_W  = 8;
  localparam int FRAC_W = 23;
  localparam int OPW    = EXP_W + FRAC_W + 1;
  localparam int M      = FRAC_W + 1;
  localparam int K      = (M + 2) / 4 + 1;
  localparam int QF     = FRAC_W + 9;
  localparam int BIAS   = (1 << (EXP_W - 1)) - 1;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, in_valid, in_recip, in_exc;
  logic [OPW-1:0] x_op, y_op;
  logic out_valid, out_sign, out_exc;
  logic signed [EXP_W+1:0] out_exp;
  logic [FRAC_W+9:0] out_mant;

  fp_recip_div #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_fp_recip_div (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_recip(in_recip),
    .in_exc(in_exc), .x_op(x_op), .y_op(y_op), .out_valid(out_valid),
    .out_sign(out_sign), .out_exp(out_exp), .out_mant(out_mant), .out_exc(out_exc)
  );

  int checks = 0;
  int fails  = 0;
  logic p_valid, p_recip, p_exc;
  logic [OPW-1:0] p_x, p_y;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [OPW-1:0] mk(input bit s, input int e, input int f);
    return {s, EXP_W'(e), FRAC_W'(f)};
  endfunction

  task automatic compare();
    bit  yz, sx, sy;
    int  ex, ey, fx, fy, eexp;
    real xm, ym, tgt, diff, tol;
    if (!p_valid) begin
      chk(out_valid == 1'b0, "R1", longint'(out_valid), 0);
      return;
    end
    chk(out_valid == 1'b1, "R1", longint'(out_valid), 1);
    sx = p_x[OPW-1];  sy = p_y[OPW-1];
    ex = int'(p_x[OPW-2:FRAC_W]);  ey = int'(p_y[OPW-2:FRAC_W]);
    fx = int'(p_x[FRAC_W-1:0]);    fy = int'(p_y[FRAC_W-1:0]);
    yz = (ey == 0) && (fy == 0);
    chk(out_exc == (yz | p_exc), yz ? "R7" : "R8", longint'(out_exc), longint'(yz | p_exc));
    if (p_recip) begin
      chk(out_sign == sy, "R4", longint'(out_sign), longint'(sy));
      eexp = 2 * BIAS - ey;
      chk(int'(out_exp) == eexp, "R4", longint'(out_exp), longint'(eexp));
    end else begin
      chk(out_sign == (sx ^ sy), "R2", longint'(out_sign), longint'(sx ^ sy));
      eexp = ex - ey + BIAS;
      chk(int'(out_exp) == eexp, "R3", longint'(out_exp), longint'(eexp));
    end
    if (yz) return;
    xm  = p_recip ? 1.0 : 1.0 + real'(fx) / (2.0 ** FRAC_W);
    ym  = 1.0 + real'(fy) / (2.0 ** FRAC_W);
    tgt = xm / ym * (2.0 ** QF);
    if (fy == 0) begin
      chk(real'(longint'(out_mant)) == tgt, "R9", longint'(out_mant), longint'(tgt));
    end else begin
      diff = real'(longint'(out_mant)) - tgt;
      if (diff < 0.0) diff = -diff;
      tol = 2.0 ** (QF - FRAC_W);
      chk(diff <= tol, p_recip ? "R6" : "R5", longint'(out_mant), longint'(tgt));
    end
  endtask

  task automatic step(input bit v, input bit r, input bit e,
                      input logic [OPW-1:0] x, input logic [OPW-1:0] y);
    @(negedge clk);
    compare();
    in_valid = v; in_recip = r; in_exc = e; x_op = x; y_op = y;
    p_valid = v;  p_recip = r;  p_exc = e;  p_x = x;  p_y = y;
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b1; in_recip = 1'b0; in_exc = 1'b1;
    x_op = mk(1, 130, 12345); y_op = mk(0, 120, 999);
    p_valid = 1'b0; p_recip = 1'b0; p_exc = 1'b0; p_x = '0; p_y = '0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(out_valid == 0 && out_sign == 0 && out_exc == 0, "R10",
          longint'({out_valid, out_sign, out_exc}), 0);
      chk(out_exp == 0 && out_mant == 0, "R10", longint'(out_mant), 0);
    end
    in_valid = 1'b0; in_exc = 1'b0;
    rst_n = 1'b1;

    step(0, 0, 0, '0, '0);
    step(1, 0, 0, mk(0, 127, 32'h400000), mk(0, 127, 0));
    step(1, 0, 0, mk(1, 200, 32'h7fffff), mk(0, 10, 0));
    step(1, 0, 0, mk(0, 127, 32'h2aaaaa), mk(1, 127, 32'h2aaaaa));
    step(1, 0, 0, mk(1, 127, 0), mk(1, 127, 32'h7fffff));
    step(1, 0, 0, mk(0, 127, 32'h7fffff), mk(0, 127, 1));
    step(1, 0, 0, mk(0, 255, 32'h123456), mk(0, 1, 32'h654321));
    step(1, 0, 0, mk(0, 1, 32'h0f0f0f), mk(0, 254, 32'h70f0f0));
    step(1, 0, 0, mk(0, 0, 0), mk(0, 255, 32'h7fffff));
    step(0, 0, 0, '0, '0);
    step(1, 0, 0, mk(0, 140, 5), mk(0, 0, 0));
    step(1, 0, 1, mk(0, 140, 5), mk(1, 0, 0));
    step(1, 1, 0, mk(0, 140, 5), mk(0, 0, 0));
    step(1, 0, 0, mk(0, 140, 5), mk(0, 0, 32'h300000));
    step(1, 0, 1, mk(0, 100, 77), mk(0, 90, 32'h111111));
    step(1, 1, 1, mk(1, 33, 7), mk(1, 90, 32'h111111));
    step(1, 1, 0, mk(0, 50, 32'h7fffff), mk(1, 127, 0));
    step(1, 1, 0, mk(1, 0, 0), mk(0, 254, 32'h7fffff));
    step(1, 1, 0, mk(0, 99, 1234), mk(0, 254, 32'h7fffff));

    for (int i = 0; i < (1 << K); i++) begin
      int lo;
      lo = int'($urandom_range(0, (1 << (FRAC_W - K)) - 1));
      step(1, 0, 0, mk(1'($urandom), int'($urandom_range(1, 254)),
                       int'($urandom_range(0, (1 << FRAC_W) - 1))),
           mk(1'($urandom), int'($urandom_range(1, 254)), (i << (FRAC_W - K)) | lo));
      step(1, 1, 0, mk(1'($urandom), int'($urandom_range(0, 255)), int'($urandom)),
           mk(1'($urandom), int'($urandom_range(1, 254)), (i << (FRAC_W - K)) | lo));
    end

    for (int n = 0; n < 3000; n++) begin
      bit v, r, e;
      int ey;
      v  = ($urandom_range(0, 3) != 0);
      r  = ($urandom_range(0, 3) == 0);
      e  = ($urandom_range(0, 15) == 0);
      ey = ($urandom_range(0, 31) == 0) ? 0 : int'($urandom_range(1, 254));
      step(v, r, e,
           mk(1'($urandom), int'($urandom_range(0, 255)), int'($urandom)),
           mk(1'($urandom), ey, ($urandom_range(0, 7) == 0) ? 0 : int'($urandom)));
    end

    step(0, 0, 0, '0, '0);
    step(0, 0, 0, '0, '0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule